// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides, for each received frame, whether a destination address that names a group of stations should be let through. The six destination-address bytes arrive one per cycle on a byte stream, with a marker on the first byte. While the bytes stream in, the block runs the Ethernet CRC-32 over them, least-significant bit of each byte first. It then bit-reverses the result and keeps its eight most significant bits as an index into a 256-entry hash table.

The table is held as eight 32-bit words that software edits one entry at a time, setting or clearing it. Any word can be read back. One cycle after the sixth address byte, the block raises a one-cycle valid strobe. The strobe carries the accept decision and the computed index. A promiscuous control input forces acceptance of every frame.

Addresses whose group bit is clear never hit the table. Exact matching of individual addresses and checking the CRC of the whole frame are handled by other blocks.

Top module: `mhf_hash_filter`

## Requirements
- R1: Synchronous active-high reset clears every table word to zero, drops `result_valid` and `accept`, and zeroes `hash_index`.
- R2: The CRC register is preset to all ones when `addr_first` marks the first byte. Each byte is folded in LSB first, using the reflected polynomial 0xEDB88320 with no final inversion. `hash_index` equals the 8 most significant bits of the bit-reversed CRC after the sixth byte.
- R3: `result_valid` is high for exactly the one cycle after the clock edge that takes the sixth address byte. `accept` is low whenever `result_valid` is low. `hash_index` holds its value until the next result.
- R4: Table entry n lives in word n[7:5], at bit position 31 - n[4:0]. Entry 0 is bit 31 of word 0, and entry 255 is bit 0 of word 7.
- R5: A cycle with `tbl_wr_en` high writes `tbl_wr_set` into entry `tbl_wr_entry` at the next edge and leaves every other entry unchanged. `tbl_rd_word` shows word `tbl_rd_sel` combinationally.
- R6: A frame whose first byte has bit 0 set (group address) is accepted when the table entry at its index is set, and rejected when it is clear. The table contents used are those present at the edge that takes the sixth byte.
- R7: A frame whose first byte has bit 0 clear is rejected whatever the table holds, unless promiscuous mode is on.
- R8: With `promisc_en` high at the edge that takes the sixth byte, the frame is accepted.
- R9: `addr_first` on any byte restarts the address from that byte. Bytes after the sixth that are not marked `addr_first` are ignored and produce no further result.
- R10: Cycles with `addr_valid` low pause the address without disturbing the CRC or the byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_valid | input | 1 | A destination-address byte is present |
| addr_byte | input | 8 | Address byte, first byte on the wire first |
| addr_first | input | 1 | Marks the first address byte of a frame |
| promisc_en | input | 1 | Accept every frame |
| tbl_wr_en | input | 1 | Write one table entry |
| tbl_wr_set | input | 1 | Value written: 1 sets the entry, 0 clears it |
| tbl_wr_entry | input | 8 | Entry number 0..255 |
| tbl_rd_sel | input | 3 | Table word to read |
| tbl_rd_word | output | 32 | Contents of the selected table word |
| result_valid | output | 1 | One-cycle strobe after the sixth byte |
| accept | output | 1 | Frame accepted (qualified by `result_valid`) |
| hash_index | output | 8 | Table index of the last address |

## Verification
The filter is driven with group addresses whose table entry was set first and then cleared. These cases separate a correct index and bit mapping from a merely plausible one. An individual address is sent with its entry set, and then again in promiscuous mode, which isolates the group-bit gate from the override. Bytes spread out with idle cycles, a restart in the middle of an address, and trailing bytes after the sixth show whether the byte counter and CRC state survive pauses and reset only on the first-byte marker. Many random addresses with random table contents and random promiscuous settings then exercise the CRC against a bit-serial model on every cycle.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

    localparam int          CRC_W         = 32;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

    // Summary of the address seen so far, presented on the byte that ends it
    typedef struct packed {
        logic             done;   // this byte completes the address
        logic             group;  // bit 0 of the first address byte
        logic [CRC_W-1:0] crc;    // CRC register including this byte
    } addr_sum_t;

    // Fold one byte into a reflected CRC-32, least-significant bit first
    function automatic logic [CRC_W-1:0] crc_fold_byte(input logic [CRC_W-1:0] c,
                                                       input logic [7:0]       d);
        logic [CRC_W-1:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i])
                r = (r >> 1) ^ CRC_POLY_REFL;
            else
                r = r >> 1;
        end
        return r;
    endfunction

    function automatic logic [CRC_W-1:0] flip_bits(input logic [CRC_W-1:0] v);
        logic [CRC_W-1:0] r;
        for (int i = 0; i < CRC_W; i++)
            r[i] = v[CRC_W-1-i];
        return r;
    endfunction

endpackage

// File: rtl/mhf_crc_track.sv
module mhf_crc_track
    import mhf_pkg::*;
#(
    parameter int ADDR_BYTES = 6
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      addr_valid,
    input  logic [7:0] addr_byte,
    input  logic      addr_first,
    output addr_sum_t sum
);
    localparam int CNT_W = $clog2(ADDR_BYTES + 1);

    logic [CRC_W-1:0] crc_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             grp_q;

    logic [CRC_W-1:0] crc_base;
    logic [CNT_W-1:0] cnt_base;
    logic             grp_cur;
    logic             take;

    always_comb begin
        crc_base  = addr_first ? {CRC_W{1'b1}} : crc_q;
        cnt_base  = addr_first ? '0 : cnt_q;
        grp_cur   = addr_first ? addr_byte[0] : grp_q;
        take      = addr_valid && (addr_first || busy_q);
        sum.crc   = crc_fold_byte(crc_base, addr_byte);
        sum.group = grp_cur;
        sum.done  = take && (cnt_base == CNT_W'(ADDR_BYTES - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q  <= {CRC_W{1'b1}};
            cnt_q  <= '0;
            busy_q <= 1'b0;
            grp_q  <= 1'b0;
        end else if (take) begin
            crc_q  <= sum.crc;
            cnt_q  <= cnt_base + CNT_W'(1);
            grp_q  <= grp_cur;
            busy_q <= !sum.done;
        end
    end

endmodule

// File: rtl/mhf_hash_table.sv
module mhf_hash_table #(
    parameter int NUM_REGS = 8,
    parameter int REG_W    = 32
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 wr_en,
    input  logic                                 wr_set,
    input  logic [$clog2(NUM_REGS*REG_W)-1:0]    wr_entry,
    input  logic [$clog2(NUM_REGS)-1:0]          rd_sel,
    output logic [REG_W-1:0]                     rd_word,
    output logic [NUM_REGS*REG_W-1:0]            flat
);
    localparam int ENTRIES = NUM_REGS * REG_W;
    localparam int IDX_W   = $clog2(ENTRIES);
    localparam int BIT_W   = $clog2(REG_W);
    localparam int SEL_W   = $clog2(NUM_REGS);

    logic [SEL_W-1:0] wr_word;
    logic [BIT_W-1:0] wr_pos;

    // Entries are numbered from the top bit of each word downwards
    assign wr_word = wr_entry[IDX_W-1:BIT_W];
    assign wr_pos  = ~wr_entry[BIT_W-1:0];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
        logic [REG_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst)
                word_q <= '0;
            else if (wr_en && (wr_word == SEL_W'(g)))
                word_q[wr_pos] <= wr_set;
        end
        assign flat[g*REG_W +: REG_W] = word_q;
    end

    assign rd_word = flat[rd_sel*REG_W +: REG_W];

endmodule

// File: rtl/mhf_decide.sv
module mhf_decide
    import mhf_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int REG_W    = 32
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  addr_sum_t                            sum,
    input  logic                                 promisc_en,
    input  logic [NUM_REGS*REG_W-1:0]            tbl_flat,
    output logic                                 result_valid,
    output logic                                 accept,
    output logic [$clog2(NUM_REGS*REG_W)-1:0]    hash_index
);
    localparam int IDX_W = $clog2(NUM_REGS * REG_W);
    localparam int BIT_W = $clog2(REG_W);

    logic [CRC_W-1:0] crc_rev;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] flat_pos;
    logic             hit;

    always_comb begin
        crc_rev  = flip_bits(sum.crc);
        idx      = crc_rev[CRC_W-1 -: IDX_W];
        flat_pos = {idx[IDX_W-1:BIT_W], ~idx[BIT_W-1:0]};
        hit      = tbl_flat[flat_pos];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_valid <= 1'b0;
            accept       <= 1'b0;
            hash_index   <= '0;
        end else begin
            result_valid <= sum.done;
            accept       <= sum.done && (promisc_en || (sum.group && hit));
            if (sum.done)
                hash_index <= idx;
        end
    end

endmodule

// File: rtl/mhf_hash_filter.sv
module mhf_hash_filter
    import mhf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int NUM_REGS   = 8,
    parameter int REG_W      = 32,
    localparam int IDX_W     = $clog2(NUM_REGS * REG_W),
    localparam int SEL_W     = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             addr_valid,
    input  logic [7:0]       addr_byte,
    input  logic             addr_first,
    input  logic             promisc_en,
    input  logic             tbl_wr_en,
    input  logic             tbl_wr_set,
    input  logic [IDX_W-1:0] tbl_wr_entry,
    input  logic [SEL_W-1:0] tbl_rd_sel,
    output logic [REG_W-1:0] tbl_rd_word,
    output logic             result_valid,
    output logic             accept,
    output logic [IDX_W-1:0] hash_index
);
    addr_sum_t                  sum;
    logic [NUM_REGS*REG_W-1:0]  tbl_flat;

    mhf_crc_track #(.ADDR_BYTES(ADDR_BYTES)) u_track (
        .clk        (clk),
        .rst        (rst),
        .addr_valid (addr_valid),
        .addr_byte  (addr_byte),
        .addr_first (addr_first),
        .sum        (sum)
    );

    mhf_hash_table #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (tbl_wr_en),
        .wr_set   (tbl_wr_set),
        .wr_entry (tbl_wr_entry),
        .rd_sel   (tbl_rd_sel),
        .rd_word  (tbl_rd_word),
        .flat     (tbl_flat)
    );

    mhf_decide #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_decide (
        .clk          (clk),
        .rst          (rst),
        .sum          (sum),
        .promisc_en   (promisc_en),
        .tbl_flat     (tbl_flat),
        .result_valid (result_valid),
        .accept       (accept),
        .hash_index   (hash_index)
    );

endmodule

// File: rtl/mhf_checker.sv
module mhf_checker #(
    parameter int NUM_REGS = 8,
    parameter int REG_W    = 32,
    localparam int ENTRIES = NUM_REGS * REG_W,
    localparam int IDX_W   = $clog2(ENTRIES),
    localparam int BIT_W   = $clog2(REG_W)
) (
    input logic               clk,
    input logic               rst,
    input logic               addr_valid,
    input logic               promisc_en,
    input logic               tbl_wr_en,
    input logic               tbl_wr_set,
    input logic [IDX_W-1:0]   tbl_wr_entry,
    input logic               result_valid,
    input logic               accept,
    input logic [ENTRIES-1:0] tbl_flat
);
    function automatic int entry_pos(input logic [IDX_W-1:0] n);
        return int'(n[IDX_W-1:BIT_W]) * REG_W + (REG_W - 1 - int'(n[BIT_W-1:0]));
    endfunction

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (tbl_flat == '0 && !result_valid && !accept));

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);

    assert_accept_gated_R3: assert property (@(posedge clk) disable iff (rst)
        !result_valid |-> !accept);

    assert_set_entry_R4: assert property (@(posedge clk) disable iff (rst)
        (tbl_wr_en && tbl_wr_set) |=> tbl_flat[entry_pos($past(tbl_wr_entry))]);

    assert_clear_entry_R5: assert property (@(posedge clk) disable iff (rst)
        (tbl_wr_en && !tbl_wr_set) |=> !tbl_flat[entry_pos($past(tbl_wr_entry))]);

    assert_promisc_accepts_R8: assert property (@(posedge clk) disable iff (rst)
        (result_valid && $past(promisc_en)) |-> accept);

    assert_result_needs_byte_R10: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> $past(addr_valid));

endmodule

bind mhf_hash_filter mhf_checker #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_mhf_checker (
    .clk          (clk),
    .rst          (rst),
    .addr_valid   (addr_valid),
    .promisc_en   (promisc_en),
    .tbl_wr_en    (tbl_wr_en),
    .tbl_wr_set   (tbl_wr_set),
    .tbl_wr_entry (tbl_wr_entry),
    .result_valid (result_valid),
    .accept       (accept),
    .tbl_flat     (tbl_flat)
);

// File: tb/mhf_hash_filter_bench.sv
module mhf_hash_filter_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        addr_valid = 1'b0;
    logic [7:0]  addr_byte = 8'h00;
    logic        addr_first = 1'b0;
    logic        promisc_en = 1'b0;
    logic        tbl_wr_en = 1'b0;
    logic        tbl_wr_set = 1'b0;
    logic [7:0]  tbl_wr_entry = 8'h00;
    logic [2:0]  tbl_rd_sel = 3'd0;
    logic [31:0] tbl_rd_word;
    logic        result_valid;
    logic        accept;
    logic [7:0]  hash_index;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    compare_on = 1'b0;
    string valid_tag = "R3";

    always #4 clk = ~clk;

    mhf_hash_filter u_mhf_hash_filter (
        .clk(clk), .rst(rst), .addr_valid(addr_valid), .addr_byte(addr_byte),
        .addr_first(addr_first), .promisc_en(promisc_en), .tbl_wr_en(tbl_wr_en),
        .tbl_wr_set(tbl_wr_set), .tbl_wr_entry(tbl_wr_entry), .tbl_rd_sel(tbl_rd_sel),
        .tbl_rd_word(tbl_rd_word), .result_valid(result_valid), .accept(accept),
        .hash_index(hash_index)
    );

    // ---------------- reference model ----------------
    bit          m_tbl [256];
    logic [31:0] m_crc;
    int          m_cnt;
    bit          m_busy, m_grp;
    bit          m_valid, m_acc;
    logic [7:0]  m_idx;
    string       m_acc_tag = "R6";

    function automatic logic [7:0] idx_from_crc(input logic [31:0] c);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[7-i] = c[i];
        return r;
    endfunction

    function automatic logic [31:0] ser_crc(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r = c;
        for (int b = 0; b < 8; b++) begin
            logic fb = r[0] ^ d[b];
            r = {1'b0, r[31:1]};
            if (fb) r = r ^ 32'hEDB88320;
        end
        return r;
    endfunction

    function automatic logic [7:0] model_hash(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int k = 0; k < 6; k++) c = ser_crc(c, a[47-8*k -: 8]);
        return idx_from_crc(c);
    endfunction

    function automatic logic [31:0] model_word(input int sel);
        logic [31:0] w;
        for (int b = 0; b < 32; b++) w[31-b] = m_tbl[sel*32 + b];
        return w;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_tbl[i]) m_tbl[i] = 1'b0;
            m_busy = 0; m_valid = 0; m_acc = 0; m_idx = 0; m_cnt = 0; m_grp = 0;
            m_crc = 32'hFFFF_FFFF;
        end else begin
            m_valid = 0; m_acc = 0;
            if (addr_valid) begin
                if (addr_first) begin
                    m_crc = 32'hFFFF_FFFF; m_cnt = 0; m_grp = addr_byte[0]; m_busy = 1;
                end
                if (m_busy) begin
                    m_crc = ser_crc(m_crc, addr_byte);
                    m_cnt++;
                    if (m_cnt == 6) begin
                        m_busy    = 0;
                        m_valid   = 1;
                        m_idx     = idx_from_crc(m_crc);
                        m_acc     = promisc_en || (m_grp && m_tbl[m_idx]);
                        m_acc_tag = promisc_en ? "R8" : (m_grp ? "R6" : "R7");
                    end
                end
            end
            if (tbl_wr_en) m_tbl[tbl_wr_entry] = tbl_wr_set;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (compare_on && !rst) begin
            chk(result_valid === m_valid, valid_tag, 32'(result_valid), 32'(m_valid));
            chk(accept === m_acc, m_valid ? m_acc_tag : "R3", 32'(accept), 32'(m_acc));
            chk(hash_index === m_idx, "R2", 32'(hash_index), 32'(m_idx));
            chk(tbl_rd_word === model_word(int'(tbl_rd_sel)), "R5", tbl_rd_word, model_word(int'(tbl_rd_sel)));
        end
    end

    // ---------------- stimulus ----------------
    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic idle();
        step(); addr_valid = 0; addr_first = 0; tbl_wr_en = 0;
    endtask

    task automatic write_entry(input logic [7:0] n, input bit v);
        step(); addr_valid = 0; addr_first = 0;
        tbl_wr_en = 1; tbl_wr_entry = n; tbl_wr_set = v;
        step(); tbl_wr_en = 0;
    endtask

    task automatic send_bytes(input logic [47:0] a, input int nbytes, input bit mark, input int gap);
        for (int k = 0; k < nbytes; k++) begin
            step(); tbl_wr_en = 0;
            addr_valid = 1; addr_byte = a[47-8*k -: 8]; addr_first = mark && (k == 0);
            for (int g = 0; g < gap; g++) begin
                step(); addr_valid = 0; addr_first = 0;
            end
        end
        step(); addr_valid = 0; addr_first = 0;
        repeat (2) step();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [47:0] grp_a, ind_b, r_addr;
        logic [7:0]  h;
        repeat (3) step();
        rst = 0;
        @(negedge clk);
        // R1: reset state
        chk(result_valid === 1'b0, "R1", 32'(result_valid), 0);
        chk(accept === 1'b0, "R1", 32'(accept), 0);
        chk(hash_index === 8'h00, "R1", 32'(hash_index), 0);
        for (int s = 0; s < 8; s++) begin
            tbl_rd_sel = 3'(s); #1;
            chk(tbl_rd_word === 32'h0, "R1", tbl_rd_word, 0);
        end
        compare_on = 1;

        // R4: entry to word/bit mapping
        write_entry(8'd0, 1); tbl_rd_sel = 3'd0; @(negedge clk);
        chk(tbl_rd_word === 32'h8000_0000, "R4", tbl_rd_word, 32'h8000_0000);
        write_entry(8'd255, 1); tbl_rd_sel = 3'd7; @(negedge clk);
        chk(tbl_rd_word === 32'h0000_0001, "R4", tbl_rd_word, 32'h0000_0001);
        write_entry(8'd37, 1); tbl_rd_sel = 3'd1; @(negedge clk);
        chk(tbl_rd_word === 32'h0400_0000, "R4", tbl_rd_word, 32'h0400_0000);
        // R5: clear one entry, neighbours keep theirs
        write_entry(8'd0, 0); tbl_rd_sel = 3'd0; @(negedge clk);
        chk(tbl_rd_word === 32'h0, "R5", tbl_rd_word, 0);
        tbl_rd_sel = 3'd7; #1;
        chk(tbl_rd_word === 32'h0000_0001, "R5", tbl_rd_word, 32'h0000_0001);

        // R6: group address hit and miss
        grp_a = 48'h01_00_5E_00_00_01;
        h = model_hash(grp_a);
        write_entry(h, 1);
        tbl_rd_sel = h[7:5];
        send_bytes(grp_a, 6, 1, 0);
        write_entry(h, 0);
        send_bytes(grp_a, 6, 1, 0);

        // R7: individual address ignores the table
        ind_b = 48'h00_1E_4F_12_CB_2C;
        write_entry(model_hash(ind_b), 1);
        send_bytes(ind_b, 6, 1, 0);
        // R8: promiscuous override
        promisc_en = 1;
        send_bytes(ind_b, 6, 1, 0);
        send_bytes(grp_a, 6, 1, 0);
        promisc_en = 0;

        // R10: idle gaps between bytes
        valid_tag = "R10";
        write_entry(h, 1);
        send_bytes(grp_a, 6, 1, 2);
        send_bytes(grp_a, 6, 1, 1);

        // R9: restart mid-address and trailing bytes
        valid_tag = "R9";
        send_bytes(48'h33_33_00_00_00_FB, 3, 1, 0);
        send_bytes(grp_a, 6, 1, 0);
        send_bytes(grp_a, 4, 0, 0);
        valid_tag = "R3";

        // R2/R6/R8: random addresses and table contents
        for (int f = 0; f < 60; f++) begin
            r_addr = {$urandom(), 16'($urandom())};
            if (f % 3 != 0) r_addr[40] = 1'b1;
            write_entry(model_hash(r_addr), 1'($urandom() % 2));
            write_entry(8'($urandom()), 1'($urandom() % 2));
            tbl_rd_sel = 3'($urandom());
            promisc_en = ($urandom() % 5) == 0;
            send_bytes(r_addr, 6, 1, f % 2);
        end
        promisc_en = 0;
        idle();
        repeat (3) step();
        summary();
        $finish;
    end

endmodule